// File: doc/BRIEF.md
# Remappable Priority Address Decoder

This block turns a CPU byte address into a choice of one memory target, together with the offset of that address inside the chosen target. There are five windows. The on-chip register file (I/O) and the internal RAM sit at bases that software can move at run time by writing an 8-bit placement register. The EEPROM and non-volatile RAM (NVRAM) windows have bases and sizes fixed by parameters. External RAM catches every address that no other window claims.

Windows may overlap, and a fixed priority settles each overlap. I/O wins over internal RAM, internal RAM over EEPROM, EEPROM over NVRAM, and NVRAM over external RAM. The decode is combinational from the address and the registered placement value. A write to the placement register therefore moves the windows from the following clock cycle.

Top module: `addr_remap_dec`

## Requirements
- R1: While `strobe` is high exactly one bit of `sel` is set; while `strobe` is low `sel` is zero. The bit positions in `sel` are: bit 0 I/O, bit 1 internal RAM, bit 2 EEPROM, bit 3 NVRAM, bit 4 external RAM.
- R2: The I/O window starts at placement bits [3:0] shifted left by 12 (placed in address bits 15:12). It covers `IO_SPAN` bytes, 0x40 by default. `offset` equals the address minus that base.
- R3: The internal RAM window starts at placement bits [7:4] shifted left by 12. It covers `IRAM_SPAN` bytes, 0x100 by default. `offset` is the address minus that base.
- R4: The EEPROM window starts at `EE_BASE` (default 0xB600) and covers `EE_SPAN` bytes (default 0x200). Its position is unaffected by any placement value.
- R5: The NVRAM window starts at `NV_BASE` (default 0xB000) and covers `NV_SPAN` bytes (default 0x1000). Its position is unaffected by any placement value.
- R6: Where windows overlap, the winner is decided in this order: I/O, then internal RAM, then EEPROM, then NVRAM.
- R7: An address claimed by no other window selects external RAM, and `offset` then equals the address.
- R8: A write on `init_we` leaves decoding unchanged in the cycle of the write. Decoding uses the new value from the next cycle on.
- R9: After reset the placement register holds `INIT_RST` (default 0x01). This puts I/O at 0x1000 and internal RAM at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_we | input | 1 | Load strobe for the placement register |
| init_wdata | input | 8 | New placement value |
| strobe | input | 1 | Address valid |
| addr | input | 16 | CPU byte address |
| sel | output | 5 | One-hot target select |
| offset | output | 16 | Address relative to the selected window base |

## Verification
Directed addresses fall on the first and last byte of each window and one byte past its end. Together they separate an off-by-one span compare from a correct one. Placement values that stack I/O, internal RAM and NVRAM on the same 4 KiB page check that priority is applied level by level, rather than by whichever window matched. The default EEPROM window lies inside the NVRAM window, so EEPROM must win there. Random addresses mixed with random placement writes compare every cycle against a bench model. Probes taken during the write cycle itself separate registered placement from a combinational bypass.

// File: rtl/addr_remap_pkg.sv
package addr_remap_pkg;
   localparam int NWIN = 5;
   // index order is the priority order: lower index wins
   typedef enum logic [2:0] {
      WIN_IO   = 3'd0,
      WIN_IRAM = 3'd1,
      WIN_EE   = 3'd2,
      WIN_NV   = 3'd3,
      WIN_XR   = 3'd4
   } win_e;
endpackage

// File: rtl/addr_remap_place.sv
module addr_remap_place #(
   parameter int            IW  = 8,
   parameter logic [IW-1:0] RST = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] wdata,
   output logic [IW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/addr_remap_match.sv
module addr_remap_match #(
   parameter int AW   = 16,
   parameter int SPAN = 64
) (
   input  logic          en,
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   output logic          hit,
   output logic [AW-1:0] off
);
   localparam logic [AW:0] SPAN_V = (AW+1)'(SPAN);
   logic [AW:0] diff;

   // borrow in bit AW makes diff larger than any legal span
   assign diff = {1'b0, addr} - {1'b0, base};
   assign hit  = en && (diff < SPAN_V);
   assign off  = diff[AW-1:0];
endmodule

// File: rtl/addr_remap_pick.sv
module addr_remap_pick #(
   parameter int N  = 5,
   parameter int AW = 16
) (
   input  logic [N-1:0]         hit,
   input  logic [N-1:0][AW-1:0] off_in,
   output logic [N-1:0]         sel,
   output logic [AW-1:0]        off
);
   logic [N:0] taken;

   assign taken[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign sel[i]     = hit[i] && !taken[i];
      assign taken[i+1] = taken[i] || hit[i];
   end

   always_comb begin
      off = '0;
      for (int i = 0; i < N; i++)
         if (sel[i]) off = off_in[i];
   end
endmodule

// File: rtl/addr_remap_dec.sv
module addr_remap_dec
   import addr_remap_pkg::*;
#(
   parameter int            AW        = 16,
   parameter int            IW        = 8,
   parameter int            IO_SPAN   = 'h40,
   parameter int            IRAM_SPAN = 'h100,
   parameter logic [AW-1:0] EE_BASE   = 16'hB600,
   parameter int            EE_SPAN   = 'h200,
   parameter logic [AW-1:0] NV_BASE   = 16'hB000,
   parameter int            NV_SPAN   = 'h1000,
   parameter logic [IW-1:0] INIT_RST  = 8'h01
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_we,
   input  logic [IW-1:0] init_wdata,
   input  logic          strobe,
   input  logic [AW-1:0] addr,
   output logic [4:0]    sel,
   output logic [AW-1:0] offset
);
   localparam int NIB   = IW / 2;
   localparam int SHIFT = AW - NIB;
   localparam int PAGE  = 1 << SHIFT;

   if (IW != 2 * NIB) begin : g_bad_iw
      $error("placement width must be even");
   end
   if (IO_SPAN < 1 || IO_SPAN > PAGE || IRAM_SPAN < 1 || IRAM_SPAN > PAGE) begin : g_bad_page
      $error("relocatable window spans must fit one page");
   end
   if (EE_SPAN < 1 || NV_SPAN < 1 ||
       int'(EE_BASE) + EE_SPAN > (1 << AW) || int'(NV_BASE) + NV_SPAN > (1 << AW)) begin : g_bad_fix
      $error("fixed window exceeds address space");
   end

   function automatic int span_of(int w);
      case (w)
         WIN_IO:   return IO_SPAN;
         WIN_IRAM: return IRAM_SPAN;
         WIN_EE:   return EE_SPAN;
         default:  return NV_SPAN;
      endcase
   endfunction

   logic [IW-1:0]              place_q;
   logic [NWIN-1:0][AW-1:0]    base;
   logic [NWIN-1:0]            hit;
   logic [NWIN-1:0][AW-1:0]    win_off;

   addr_remap_place #(.IW(IW), .RST(INIT_RST)) u_place (
      .clk(clk), .rst_n(rst_n), .we(init_we), .wdata(init_wdata), .q(place_q)
   );

   assign base[WIN_IO]   = {place_q[NIB-1:0],  {SHIFT{1'b0}}};
   assign base[WIN_IRAM] = {place_q[IW-1:NIB], {SHIFT{1'b0}}};
   assign base[WIN_EE]   = EE_BASE;
   assign base[WIN_NV]   = NV_BASE;
   assign base[WIN_XR]   = '0;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      if (w == WIN_XR) begin : g_fallback
         assign hit[w]     = strobe;
         assign win_off[w] = addr;
      end else begin : g_range
         addr_remap_match #(.AW(AW), .SPAN(span_of(w))) u_match (
            .en(strobe), .addr(addr), .base(base[w]),
            .hit(hit[w]), .off(win_off[w])
         );
      end
   end

   addr_remap_pick #(.N(NWIN), .AW(AW)) u_pick (
      .hit(hit), .off_in(win_off), .sel(sel), .off(offset)
   );
endmodule

// File: rtl/addr_remap_dec_chk.sv
module addr_remap_dec_chk #(
   parameter int AW = 16,
   parameter int IW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          init_we,
   input logic [IW-1:0] init_wdata,
   input logic          strobe,
   input logic [AW-1:0] addr,
   input logic [4:0]    sel,
   input logic [AW-1:0] offset,
   input logic [IW-1:0] place_q
);
   AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> $countones(sel) == 1); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |-> sel == '0); // R1
   AST_IO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && addr[AW-1:AW-4] == place_q[3:0] && addr[AW-5:6] == '0) |-> sel[0]); // R6
   AST_FALLBACK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      sel[4] |-> offset == addr); // R7
   AST_PLACE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      init_we |=> place_q == $past(init_wdata)); // R8
   AST_PLACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !init_we |=> $stable(place_q)); // R8
endmodule

bind addr_remap_dec addr_remap_dec_chk #(.AW(AW), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_wdata(init_wdata),
   .strobe(strobe), .addr(addr), .sel(sel), .offset(offset), .place_q(place_q)
);

// File: tb/sim_addr_remap_dec.sv
module sim_addr_remap_dec;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_we = 1'b0;
   logic [7:0]  init_wdata = '0;
   logic        strobe = 1'b0;
   logic [15:0] addr = '0;
   logic [4:0]  sel;
   logic [15:0] offset;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [7:0] mplace = 8'h01;

   always #(CLK_PERIOD/2) clk = ~clk;

   addr_remap_dec u0 (
      .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_wdata(init_wdata),
      .strobe(strobe), .addr(addr), .sel(sel), .offset(offset)
   );

   function automatic bit inwin(logic [15:0] a, logic [15:0] b, int span);
      return (int'(a) >= int'(b)) && (int'(a) - int'(b) < span);
   endfunction

   function automatic logic [4:0] exp_sel(logic [15:0] a, logic [7:0] p, logic s);
      logic [15:0] iob = {p[3:0], 12'h000};
      logic [15:0] rmb = {p[7:4], 12'h000};
      if (!s) return 5'b00000;
      if (inwin(a, iob, 'h40))     return 5'b00001;
      if (inwin(a, rmb, 'h100))    return 5'b00010;
      if (inwin(a, 16'hB600, 'h200))  return 5'b00100;
      if (inwin(a, 16'hB000, 'h1000)) return 5'b01000;
      return 5'b10000;
   endfunction

   function automatic logic [15:0] exp_off(logic [15:0] a, logic [7:0] p, logic s);
      logic [4:0] e = exp_sel(a, p, s);
      case (e)
         5'b00001: return a - {p[3:0], 12'h000};
         5'b00010: return a - {p[7:4], 12'h000};
         5'b00100: return a - 16'hB600;
         5'b01000: return a - 16'hB000;
         5'b10000: return a;
         default:  return 16'h0000;
      endcase
   endfunction

   task automatic check(string req, logic [4:0] es, logic [15:0] eo);
      total++;
      if (sel !== es || offset !== eo) begin
         bad++;
         $display("FAIL %s addr=%h sel=%b off=%h expected sel=%b off=%h",
                  req, addr, sel, offset, es, eo);
      end
   endtask

   task automatic probe(string req, logic [15:0] a, logic s = 1'b1);
      @(negedge clk);
      addr = a; strobe = s;
      #1 check(req, exp_sel(a, mplace, s), exp_off(a, mplace, s));
   endtask

   task automatic place(logic [7:0] v, logic [15:0] a_probe);
      @(negedge clk);
      init_we = 1'b1; init_wdata = v; addr = a_probe; strobe = 1'b1;
      #1 check("R8", exp_sel(a_probe, mplace, 1'b1), exp_off(a_probe, mplace, 1'b1));
      @(posedge clk);
      mplace = v;
      #1 init_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R9 reset placement: I/O at 0x1000, internal RAM at 0x0000
      probe("R9", 16'h1000);
      probe("R9", 16'h0000);
      probe("R1", 16'h1000, 1'b0);
      // R2 I/O window edges
      probe("R2", 16'h103F);
      probe("R2", 16'h1040);
      // R3 internal RAM edges
      probe("R3", 16'h00FF);
      probe("R3", 16'h0100);
      // R4 EEPROM edges, R5 NVRAM edges, R6 EEPROM over NVRAM
      probe("R4", 16'hB600);
      probe("R4", 16'hB7FF);
      probe("R5", 16'hB800);
      probe("R5", 16'hB000);
      probe("R5", 16'hBFFF);
      probe("R7", 16'hC000);
      probe("R7", 16'hFFFF);
      // R8 move both windows onto 0xB000 page; probe shows old decode
      place(8'hBB, 16'hB000);
      probe("R6", 16'hB000);
      probe("R6", 16'hB040);
      probe("R6", 16'hB100);
      probe("R4", 16'hB600);
      probe("R7", 16'h1000);
      place(8'h2C, 16'hC000);
      probe("R2", 16'hC010);
      probe("R3", 16'h20FF);
      probe("R4", 16'hB7FF);
      probe("R1", 16'h20FF, 1'b0);
      // random mix
      void'($urandom(32'h5EED));
      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(0, 9) == 0)
            place(8'($urandom), 16'($urandom));
         else if ($urandom_range(0, 1) == 0)
            probe("R6", {mplace[$urandom_range(0,1) ? 3 : 7 -: 4], 4'h0, 8'($urandom)},
                  $urandom_range(0, 7) != 0);
         else
            probe("R1", 16'($urandom), $urandom_range(0, 7) != 0);
      end
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule